// File: doc/BRIEF.md
# Window Comparator Alert Controller

This block checks every new 8-bit conversion result against two programmable thresholds, a floor and a ceiling. A result above the ceiling sets an over-range flag and a result below the floor sets an under-range flag. The two flags drive one alert output. The pin polarity can be selected, and the pin can be released to high impedance through a separate output-enable signal that feeds the pad. The flags can also be reported in the top bit of the 16-bit result word.

A host reaches six registers through a pointer-addressed port: the result word, the alert status, the configuration, the floor, the ceiling and a hysteresis margin. Writes take effect at the clock edge, and reads are combinational on the pointer. The alert flags work in one of two modes. In self-clearing mode a flag drops once a result comes back inside its threshold by more than the hysteresis margin. In hold mode a flag stays set until the host writes a one to its status bit.

Top module: `alertWindowCtrl`

## Requirements
- R1: After reset the configuration reads 0000h, the floor reads 0000h, the ceiling reads 0FF0h (threshold FFh), the hysteresis reads 0000h, the status reads 0000h, and the result word, alertOe and both flags are zero.
- R2: Pointer map: 0 is the result word (read only), 1 is status, 2 is configuration, 3 is floor, 4 is ceiling, 5 is hysteresis. Floor, ceiling and hysteresis hold 8 bits in data bits 11:4, and their other bits are ignored on write and read as zero. Any other pointer reads 0000h, and writes to it change nothing.
- R3: The configuration occupies bits 7:0. Bit 1 is reserved and always reads zero. Bits 7:5 (cycle time, where zero means no automatic conversion), bit 4 (hold mode), bit 3 (flag-in-word enable), bit 2 (pin enable) and bit 0 (polarity) read back as written.
- R4: On a cycle with resultValid high and resultIn above the ceiling, status bit 1 (over-range) is set from the next cycle on.
- R5: On a cycle with resultValid high and resultIn below the floor, status bit 0 (under-range) is set from the next cycle on.
- R6: With configuration bit 4 at 0, the over-range flag clears on a valid result below the ceiling minus the hysteresis, saturated at 0. The under-range flag clears on a valid result above the floor plus the hysteresis, saturated at FFh. Between these points a flag keeps its value.
- R7: With configuration bit 4 at 1, no result clears a flag. Writing status with bit 1 or bit 0 set clears the over-range or under-range flag, unless the same cycle sets that flag again. With bit 4 at 0, writes to status are ignored.
- R8: The result word, on resultWord and at pointer 0, carries the last valid result in bits 11:4. Bit 15 is (over or under) AND configuration bit 3. All other bits are zero.
- R9: alertPin equals (over or under) when configuration bit 0 is 1, and its inverse when bit 0 is 0.
- R10: alertOe equals configuration bit 2. When it is low, the pad floats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regPtr | input | 8 | Register pointer |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for regPtr (combinational) |
| resultValid | input | 1 | New conversion result strobe |
| resultIn | input | 8 | Conversion result |
| resultWord | output | 16 | Result word with alert flag |
| alertPin | output | 1 | Alert level after polarity |
| alertOe | output | 1 | Alert pad output enable |

## Verification
The assertions assume that resultIn is meaningful only in a cycle where resultValid is high. They also assume that a register write and a result strobe in the same cycle are both evaluated against the register values from before the edge. The stimulus drives every input on the falling clock edge. It sets thresholds at, just inside and just beyond each hysteresis point, and it includes hysteresis values that force saturation at both ends of the range. It pairs a hold-mode clear with a result that sets the same flag again in that cycle, and it writes status in self-clearing mode to show that the write has no effect.

// File: rtl/awcPkg.sv
package awcPkg;
  // pointer codes
  localparam int PTR_RESULT = 0;
  localparam int PTR_STATUS = 1;
  localparam int PTR_CFG    = 2;
  localparam int PTR_FLOOR  = 3;
  localparam int PTR_CEIL   = 4;
  localparam int PTR_HYST   = 5;

  // configuration bit positions
  localparam int CFG_POL    = 0;
  localparam int CFG_RSV    = 1;
  localparam int CFG_PIN_EN = 2;
  localparam int CFG_FLAG   = 3;
  localparam int CFG_HOLD   = 4;
  localparam int CFG_W      = 8;

  // status bit positions
  localparam int ST_UNDER = 0;
  localparam int ST_OVER  = 1;

  typedef struct packed {
    logic sample;
    logic wrFloor;
    logic wrCeil;
    logic wrHyst;
    logic clrOver;
    logic clrUnder;
    logic holdMode;
  } awcStrobe_t;
endpackage

// File: rtl/awcDatapath.sv
module awcDatapath #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  awcPkg::awcStrobe_t  stb,
  input  logic [DATA_W-1:0]   wrField,
  input  logic [DATA_W-1:0]   resultIn,
  output logic [DATA_W-1:0]   floorLim,
  output logic [DATA_W-1:0]   ceilLim,
  output logic [DATA_W-1:0]   hystVal,
  output logic [DATA_W-1:0]   lastVal,
  output logic                overFlag,
  output logic                underFlag
);
  localparam logic [DATA_W-1:0] FULL = '1;

  logic               isOver, isUnder, overRel, underRel;
  logic [DATA_W-1:0]  ceilThr, floorThr;
  logic [DATA_W:0]    floorSum;

  always_comb begin
    isOver   = resultIn > ceilLim;
    isUnder  = resultIn < floorLim;
    ceilThr  = (ceilLim > hystVal) ? ceilLim - hystVal : '0;
    floorSum = {1'b0, floorLim} + {1'b0, hystVal};
    floorThr = floorSum[DATA_W] ? FULL : floorSum[DATA_W-1:0];
    overRel  = resultIn < ceilThr;
    underRel = resultIn > floorThr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      floorLim <= '0;
      ceilLim  <= FULL;
      hystVal  <= '0;
      lastVal  <= '0;
    end else begin
      if (stb.wrFloor) floorLim <= wrField;
      if (stb.wrCeil)  ceilLim  <= wrField;
      if (stb.wrHyst)  hystVal  <= wrField;
      if (stb.sample)  lastVal  <= resultIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overFlag  <= 1'b0;
      underFlag <= 1'b0;
    end else begin
      if (stb.sample && isOver) overFlag <= 1'b1;
      else if (stb.sample && !stb.holdMode && overRel) overFlag <= 1'b0;
      else if (stb.clrOver) overFlag <= 1'b0;

      if (stb.sample && isUnder) underFlag <= 1'b1;
      else if (stb.sample && !stb.holdMode && underRel) underFlag <= 1'b0;
      else if (stb.clrUnder) underFlag <= 1'b0;
    end
  end

  // R4
  over_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sample && resultIn > ceilLim) |=> overFlag);
  // R5
  under_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sample && resultIn < floorLim) |=> underFlag);
  // R6
  over_selfclr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sample && !stb.holdMode &&
     ({1'b0, resultIn} + {1'b0, hystVal} < {1'b0, ceilLim})) |=> !overFlag);
  // R6
  under_selfclr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sample && !stb.holdMode &&
     ({1'b0, resultIn} > {1'b0, floorLim} + {1'b0, hystVal})) |=> !underFlag);
  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.holdMode && overFlag && !stb.clrOver) |=> overFlag);
  // R7
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrUnder && !(stb.sample && resultIn < floorLim)) |=> !underFlag);
endmodule

// File: rtl/awcCtrl.sv
module awcCtrl #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 8,
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [PTR_W-1:0]    regPtr,
  input  logic [WORD_W-1:0]   wrData,
  input  logic                resultValid,
  input  logic [DATA_W-1:0]   floorLim,
  input  logic [DATA_W-1:0]   ceilLim,
  input  logic [DATA_W-1:0]   hystVal,
  input  logic [DATA_W-1:0]   lastVal,
  input  logic                overFlag,
  input  logic                underFlag,
  output awcPkg::awcStrobe_t  stb,
  output logic [DATA_W-1:0]   wrField,
  output logic [WORD_W-1:0]   rdData,
  output logic [WORD_W-1:0]   resultWord,
  output logic                alertPin,
  output logic                alertOe
);
  import awcPkg::*;
  localparam int FIELD_LSB = 4;
  localparam logic [CFG_W-1:0] CFG_MASK = ~(CFG_W'(1) << CFG_RSV);

  logic [CFG_W-1:0] cfgReg;
  logic             anyAlert;
  int               ptrIdx;

  assign ptrIdx  = int'(regPtr);
  assign wrField = wrData[FIELD_LSB +: DATA_W];

  always_comb begin
    stb.sample   = resultValid;
    stb.holdMode = cfgReg[CFG_HOLD];
    stb.wrFloor  = regWe && ptrIdx == PTR_FLOOR;
    stb.wrCeil   = regWe && ptrIdx == PTR_CEIL;
    stb.wrHyst   = regWe && ptrIdx == PTR_HYST;
    stb.clrOver  = regWe && ptrIdx == PTR_STATUS && cfgReg[CFG_HOLD] && wrData[ST_OVER];
    stb.clrUnder = regWe && ptrIdx == PTR_STATUS && cfgReg[CFG_HOLD] && wrData[ST_UNDER];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           cfgReg <= '0;
    else if (regWe && ptrIdx == PTR_CFG) cfgReg <= wrData[CFG_W-1:0] & CFG_MASK;
  end

  assign anyAlert = overFlag | underFlag;
  assign alertPin = cfgReg[CFG_POL] ? anyAlert : ~anyAlert;
  assign alertOe  = cfgReg[CFG_PIN_EN];

  always_comb begin
    resultWord = '0;
    resultWord[FIELD_LSB +: DATA_W] = lastVal;
    resultWord[WORD_W-1] = anyAlert & cfgReg[CFG_FLAG];
  end

  always_comb begin
    rdData = '0;
    case (ptrIdx)
      PTR_RESULT: rdData = resultWord;
      PTR_STATUS: begin
        rdData[ST_OVER]  = overFlag;
        rdData[ST_UNDER] = underFlag;
      end
      PTR_CFG:    rdData[CFG_W-1:0] = cfgReg;
      PTR_FLOOR:  rdData[FIELD_LSB +: DATA_W] = floorLim;
      PTR_CEIL:   rdData[FIELD_LSB +: DATA_W] = ceilLim;
      PTR_HYST:   rdData[FIELD_LSB +: DATA_W] = hystVal;
      default:    rdData = '0;
    endcase
  end

  // R3
  cfg_rsv_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReg[CFG_RSV]);
  // R8
  word_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(overFlag || underFlag) |-> !resultWord[WORD_W-1]);
  // R7
  selfclr_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReg[CFG_HOLD] |-> !(stb.clrOver || stb.clrUnder));
endmodule

// File: rtl/alertWindowCtrl.sv
module alertWindowCtrl #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [PTR_W-1:0]  regPtr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  input  logic              resultValid,
  input  logic [DATA_W-1:0] resultIn,
  output logic [WORD_W-1:0] resultWord,
  output logic              alertPin,
  output logic              alertOe
);
  awcPkg::awcStrobe_t stb;
  logic [DATA_W-1:0]  wrField, floorLim, ceilLim, hystVal, lastVal;
  logic               overFlag, underFlag;

  awcCtrl #(.DATA_W(DATA_W), .PTR_W(PTR_W), .WORD_W(WORD_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regPtr(regPtr), .wrData(wrData),
    .resultValid(resultValid), .floorLim(floorLim), .ceilLim(ceilLim),
    .hystVal(hystVal), .lastVal(lastVal), .overFlag(overFlag),
    .underFlag(underFlag), .stb(stb), .wrField(wrField), .rdData(rdData),
    .resultWord(resultWord), .alertPin(alertPin), .alertOe(alertOe)
  );

  awcDatapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrField(wrField), .resultIn(resultIn),
    .floorLim(floorLim), .ceilLim(ceilLim), .hystVal(hystVal),
    .lastVal(lastVal), .overFlag(overFlag), .underFlag(underFlag)
  );
endmodule

// File: tb/test_alertWindowCtrl.sv
module test_alertWindowCtrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regPtr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        resultValid = 1'b0;
  logic [7:0]  resultIn = '0;
  logic [15:0] resultWord;
  logic        alertPin, alertOe;

  int checks = 0;
  int failures = 0;
  // reference state
  int mCfg = 0, mLo = 0, mHi = 255, mHy = 0, mLast = 0, mOv = 0, mUn = 0;

  always #10 clk = ~clk;

  alertWindowCtrl i_alertWindowCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regPtr(regPtr), .wrData(wrData),
    .rdData(rdData), .resultValid(resultValid), .resultIn(resultIn),
    .resultWord(resultWord), .alertPin(alertPin), .alertOe(alertOe)
  );

  function automatic int expWord();
    int flag = ((mOv | mUn) != 0 && ((mCfg >> 3) & 1) != 0) ? 1 : 0;
    return (flag << 15) | (mLast << 4);
  endfunction

  function automatic int expRead(int p);
    case (p)
      0: return expWord();
      1: return (mOv << 1) | mUn;
      2: return mCfg;
      3: return mLo << 4;
      4: return mHi << 4;
      5: return mHy << 4;
      default: return 0;
    endcase
  endfunction

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic we, int p, int wd, logic v, int r, string tag);
    int hold, ovN, unN, any;
    @(negedge clk);
    regWe = we; regPtr = 8'(p); wrData = 16'(wd); resultValid = v; resultIn = 8'(r);
    #1;
    any = mOv | mUn;
    cmp(tag, int'(rdData), expRead(p));
    cmp("R8", int'(resultWord), expWord());
    cmp("R9", int'(alertPin), ((mCfg & 1) != 0) ? any : 1 - any);
    cmp("R10", int'(alertOe), (mCfg >> 2) & 1);
    // next state
    hold = (mCfg >> 4) & 1;
    ovN = mOv; unN = mUn;
    if (we && p == 1 && hold != 0) begin
      if ((wd & 2) != 0) ovN = 0;
      if ((wd & 1) != 0) unN = 0;
    end
    if (v) begin
      if (r > mHi) ovN = 1;
      else if (hold == 0 && r < ((mHi > mHy) ? mHi - mHy : 0)) ovN = 0;
      if (r < mLo) unN = 1;
      else if (hold == 0 && r > ((mLo + mHy > 255) ? 255 : mLo + mHy)) unN = 0;
      mLast = r;
    end
    mOv = ovN; mUn = unN;
    if (we) begin
      case (p)
        2: mCfg = wd & 'hFD;
        3: mLo = (wd >> 4) & 255;
        4: mHi = (wd >> 4) & 255;
        5: mHy = (wd >> 4) & 255;
        default: ;
      endcase
    end
  endtask

  task automatic rd(int p, string tag);
    step(1'b0, p, 0, 1'b0, 0, tag);
  endtask
  task automatic wr(int p, int d, string tag);
    step(1'b1, p, d, 1'b0, 0, tag);
  endtask
  task automatic conv(int r, int p, string tag);
    step(1'b0, p, 0, 1'b1, r, tag);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    for (int p = 0; p < 6; p++) rd(p, "R1");
    // R2 unmapped pointers and reserved bits
    rd(7, "R2"); rd(255, "R2");
    wr(9, 'hFFFF, "R2");
    for (int p = 0; p < 6; p++) rd(p, "R2");
    wr(3, 'hF405, "R2"); rd(3, "R2");
    // R3 config readback, reserved bit
    wr(2, 'hFFFF, "R3"); rd(2, "R3");
    wr(2, 'h00E2, "R3"); rd(2, "R3");
    // self-clearing mode, pin on, active high, flag in word
    wr(2, 'h000D, "R3");
    wr(3, 'h0400, "R2"); wr(4, 'h0C00, "R2"); wr(5, 'h0100, "R2");
    conv('hC0, 1, "R4"); rd(1, "R4");
    conv('hC1, 1, "R4"); rd(1, "R4"); rd(0, "R8");
    conv('hB8, 1, "R6"); conv('hB0, 1, "R6"); rd(1, "R6");
    conv('hAF, 1, "R6"); rd(1, "R6");
    conv('h40, 1, "R5"); conv('h3F, 1, "R5"); rd(1, "R5");
    conv('h50, 1, "R6"); rd(1, "R6");
    wr(1, 3, "R7"); rd(1, "R7");
    conv('h51, 1, "R6"); rd(1, "R6");
    // saturation of both thresholds
    wr(5, 'h0F00, "R6");
    conv('hFF, 1, "R4"); conv('h00, 1, "R6"); rd(1, "R6");
    conv('hFF, 1, "R6"); rd(1, "R6");
    wr(5, 'h0100, "R6"); conv('h80, 1, "R6"); rd(1, "R6");
    // hold mode, active low, flag word off
    wr(2, 'h0014, "R3");
    conv('hD0, 1, "R7"); conv('h80, 1, "R7"); rd(1, "R7"); rd(0, "R8");
    conv('h10, 1, "R7"); conv('h80, 1, "R7"); rd(1, "R9");
    wr(1, 2, "R7"); rd(1, "R7");
    step(1'b1, 1, 1, 1'b1, 'h05, "R7"); rd(1, "R7");
    wr(1, 1, "R7"); rd(1, "R7");
    // pin disabled
    conv('hF0, 1, "R4"); wr(2, 'h0010, "R10"); rd(1, "R10");
    wr(2, 'h0019, "R9"); rd(0, "R8");
    wr(1, 2, "R7"); rd(1, "R7"); rd(0, "R8");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule